// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block holds the per-line control state of an interrupt controller: an enable bit, a pending bit and an 8-bit priority for each line. Lines come in groups of 32, and `NUM_GROUPS` sets how many groups are built. A 32-bit register bus reads and changes this state. Enable and pending state each have two bus views. One view sets bits where a 1 is written, and the other clears them. Both views read back the same state vector.

The block also has four other views:
- a read-only view of the per-line active inputs,
- byte-packed priority words,
- a software trigger that makes one line pending, selected by a 9-bit line number,
- a type word that reports how many groups are built.

Hardware request pulses on `hw_req` set pending bits directly. The enable, pending and priority vectors leave the block unchanged for an arbiter downstream. A two-state bus machine gives reads a fixed one-cycle latency:
- `BUS_IDLE` moves to `BUS_RESP` when a read is accepted, and otherwise stays in `BUS_IDLE`.
- `BUS_RESP` stays in `BUS_RESP` on a back-to-back read, and otherwise returns to `BUS_IDLE`.

Word address map, with `g` the group index and `w` the priority word index:

| Address | View |
|---|---|
| 0x000 | type |
| 0x010+g | set-enable |
| 0x020+g | clear-enable |
| 0x030+g | set-pending |
| 0x040+g | clear-pending |
| 0x050+g | active |
| 0x100+w | priority |
| 0x200 | trigger |

Top module: `irqb_bank`

## Requirements
- R1: In a set-enable write (0x010+g), each 1 bit m enables line 32g+m and each 0 bit has no effect. Several bits may change in one write. A read of set-enable returns the enable state.
- R2: In a clear-enable write (0x020+g), each 1 bit m disables line 32g+m. A read of clear-enable returns the same enable state as the set-enable view.
- R3: Set-pending (0x030+g) and clear-pending (0x040+g) writes follow the same write-one rules on the pending state. Reads of both views return the pending state.
- R4: A `hw_req` bit that is high in a cycle makes the line pending on the next edge. A clear-pending write to the same line in the same cycle loses, so the line stays pending. Pending bits clear only through the clear-pending view.
- R5: Reading the active view (0x050+g) returns `hw_active` bits 32g+31..32g. Writes to the active view change nothing.
- R6: Priority word w (0x100+w) holds line 4w+k in bits 8k+7..8k. `irq_priority` bits 8i+7..8i carry the priority of line i. A priority field changes only through a write to its word.
- R7: A write to the trigger (0x200) with bits 8:0 = i sets the pending bit of line i when i < 32*NUM_GROUPS. A larger i changes nothing.
- R8: The type word (0x000) reads NUM_GROUPS-1 in bits 3:0, with all other bits zero.
- R9: `bus_rvalid` is high in exactly the cycle after an accepted read, and `bus_rdata` is valid with it. Reads of unmapped addresses, of groups at or beyond NUM_GROUPS, and of the trigger return 0. Writes to those addresses have no effect.
- R10: After reset, all enable, pending and priority state is zero and `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| hw_req | input | 32*NUM_GROUPS | Per-line hardware request pulses |
| hw_active | input | 32*NUM_GROUPS | Per-line active status |
| irq_enable | output | 32*NUM_GROUPS | Enable state per line |
| irq_pending | output | 32*NUM_GROUPS | Pending state per line |
| irq_priority | output | 256*NUM_GROUPS | Priority byte per line |

## Verification
The bench writes through one alias view and reads back through the other. A design that kept separate set and clear registers would then show stale data. It drives a hardware request and a clear-pending write on the same line in the same cycle. A design where the clear wins would drop that request. It sends the trigger one line number past the last line and writes out-of-range group addresses. A design with loose bound checks would then corrupt a real line, since the index wraps or aliases. It also reads a priority word next to one that was written, which catches a shifted byte layout.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
    localparam int ADDR_W = 10;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_TYPE,
        RG_SETEN,
        RG_CLREN,
        RG_SETPD,
        RG_CLRPD,
        RG_ACTIVE,
        RG_PRIO,
        RG_TRIG
    } region_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;
endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
    import irqb_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [3:0]        grp,
    output logic [7:0]        word
);
    localparam int PRIO_WORDS = NUM_GROUPS * 8;

    logic grp_ok;

    assign grp    = addr[3:0];
    assign word   = addr[7:0];
    assign grp_ok = {28'd0, addr[3:0]} < 32'(NUM_GROUPS);

    always_comb begin
        region = RG_NONE;
        unique case (addr[9:8])
            2'b00: begin
                unique case (addr[7:4])
                    4'h0:    if (addr[3:0] == 4'd0) region = RG_TYPE;
                    4'h1:    if (grp_ok) region = RG_SETEN;
                    4'h2:    if (grp_ok) region = RG_CLREN;
                    4'h3:    if (grp_ok) region = RG_SETPD;
                    4'h4:    if (grp_ok) region = RG_CLRPD;
                    4'h5:    if (grp_ok) region = RG_ACTIVE;
                    default: region = RG_NONE;
                endcase
            end
            2'b01:   if ({24'd0, addr[7:0]} < 32'(PRIO_WORDS)) region = RG_PRIO;
            2'b10:   if (addr[7:0] == 8'd0) region = RG_TRIG;
            default: region = RG_NONE;
        endcase
    end
endmodule

// File: rtl/irqb_state.sv
module irqb_state
    import irqb_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  region_e                    region,
    input  logic [3:0]                 grp,
    input  logic [WORD_W-1:0]          wdata,
    input  logic [32*NUM_GROUPS-1:0]   hw_req,
    output logic [32*NUM_GROUPS-1:0]   enable,
    output logic [32*NUM_GROUPS-1:0]   pending
);
    localparam int NUM_LINES = 32 * NUM_GROUPS;

    logic [NUM_LINES-1:0] en_q, pd_q;
    logic [NUM_LINES-1:0] set_en, clr_en, set_pd, clr_pd, trig;
    logic [8:0]           trig_id;

    assign trig_id = wdata[8:0];

    always_comb begin
        set_en = '0;
        clr_en = '0;
        set_pd = '0;
        clr_pd = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (wr_en && grp == 4'(g)) begin
                unique case (region)
                    RG_SETEN: set_en[32*g +: 32] = wdata;
                    RG_CLREN: clr_en[32*g +: 32] = wdata;
                    RG_SETPD: set_pd[32*g +: 32] = wdata;
                    RG_CLRPD: clr_pd[32*g +: 32] = wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        trig = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            trig[i] = wr_en && (region == RG_TRIG) && (trig_id == 9'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            pd_q <= '0;
        end else begin
            en_q <= (en_q & ~clr_en) | set_en;
            pd_q <= (pd_q & ~clr_pd) | set_pd | trig | hw_req;
        end
    end

    assign enable  = en_q;
    assign pending = pd_q;

    assert_hw_sets_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_req) |=> ((pd_q & $past(hw_req)) == $past(hw_req)));

    assert_pending_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && region == RG_CLRPD) |=> ((pd_q & $past(pd_q)) == $past(pd_q)));

    assert_enable_bus_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (region == RG_SETEN || region == RG_CLREN)) |=> $stable(en_q));
endmodule

// File: rtl/irqb_prio.sv
module irqb_prio
    import irqb_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  region_e                     region,
    input  logic [7:0]                  word,
    input  logic [WORD_W-1:0]           wdata,
    output logic [WORD_W-1:0]           rd_word,
    output logic [256*NUM_GROUPS-1:0]   prio_flat
);
    localparam int PRIO_WORDS = NUM_GROUPS * 8;

    logic [WORD_W-1:0] prio_q [PRIO_WORDS];

    for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q[w] <= '0;
            end else if (wr_en && region == RG_PRIO && word == 8'(w)) begin
                prio_q[w] <= wdata;
            end
        end
        assign prio_flat[WORD_W*w +: WORD_W] = prio_q[w];
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < PRIO_WORDS; w++) begin
            if (word == 8'(w)) rd_word = prio_q[w];
        end
    end

    assert_prio_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && region == RG_PRIO) |=> $stable(prio_flat));
endmodule

// File: rtl/irqb_bank.sv
module irqb_bank
    import irqb_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_req,
    input  logic                        bus_we,
    input  logic [9:0]                  bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        bus_rvalid,
    input  logic [32*NUM_GROUPS-1:0]    hw_req,
    input  logic [32*NUM_GROUPS-1:0]    hw_active,
    output logic [32*NUM_GROUPS-1:0]    irq_enable,
    output logic [32*NUM_GROUPS-1:0]    irq_pending,
    output logic [256*NUM_GROUPS-1:0]   irq_priority
);
    region_e           region;
    logic [3:0]        grp;
    logic [7:0]        word;
    logic              wr_en, rd_en;
    logic [31:0]       prio_word, en_w, pd_w, act_w, rd_mux;
    bus_state_e        state_q, state_d;
    logic [31:0]       rdata_q;

    assign wr_en = bus_req && bus_we;
    assign rd_en = bus_req && !bus_we;

    irqb_decode #(.NUM_GROUPS(NUM_GROUPS)) u_decode (
        .addr   (bus_addr),
        .region (region),
        .grp    (grp),
        .word   (word)
    );

    irqb_state #(.NUM_GROUPS(NUM_GROUPS)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .region  (region),
        .grp     (grp),
        .wdata   (bus_wdata),
        .hw_req  (hw_req),
        .enable  (irq_enable),
        .pending (irq_pending)
    );

    irqb_prio #(.NUM_GROUPS(NUM_GROUPS)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .region    (region),
        .word      (word),
        .wdata     (bus_wdata),
        .rd_word   (prio_word),
        .prio_flat (irq_priority)
    );

    always_comb begin
        en_w  = '0;
        pd_w  = '0;
        act_w = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp == 4'(g)) begin
                en_w  = irq_enable[32*g +: 32];
                pd_w  = irq_pending[32*g +: 32];
                act_w = hw_active[32*g +: 32];
            end
        end
    end

    always_comb begin
        unique case (region)
            RG_TYPE:            rd_mux = 32'(NUM_GROUPS - 1) & 32'hF;
            RG_SETEN, RG_CLREN: rd_mux = en_w;
            RG_SETPD, RG_CLRPD: rd_mux = pd_w;
            RG_ACTIVE:          rd_mux = act_w;
            RG_PRIO:            rd_mux = prio_word;
            default:            rd_mux = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_en) state_d = BUS_RESP;
            BUS_RESP: state_d = rd_en ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
        else            rdata_q <= '0;
    end

    assign bus_rvalid = (state_q == BUS_RESP);
    assign bus_rdata  = rdata_q;

    assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid);

    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !bus_rvalid);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RG_NONE) |=> (bus_rdata == 32'd0));

    assert_type_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RG_TYPE) |=> (bus_rdata == (32'(NUM_GROUPS - 1) & 32'hF)));
endmodule

// File: tb/irqb_bank_test.sv
module irqb_bank_test;
    localparam int NG = 2;
    localparam int NL = 32 * NG;

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [31:0] data;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'h000, 32'h0000_0001, 4'd8},   // R8 type word
        '{1'b1, 10'h010, 32'h0000_00F0, 4'd1},
        '{1'b0, 10'h010, 32'h0000_00F0, 4'd1},   // R1 set several bits
        '{1'b1, 10'h010, 32'h0000_0003, 4'd1},
        '{1'b0, 10'h020, 32'h0000_00F3, 4'd2},   // R2 clear view reads enable
        '{1'b1, 10'h020, 32'h0000_0030, 4'd2},
        '{1'b0, 10'h010, 32'h0000_00C3, 4'd2},   // R2 clear two bits
        '{1'b1, 10'h010, 32'h0000_0000, 4'd1},
        '{1'b0, 10'h010, 32'h0000_00C3, 4'd1},   // R1 zeros no effect
        '{1'b1, 10'h011, 32'h8000_0001, 4'd1},
        '{1'b0, 10'h021, 32'h8000_0001, 4'd1},   // R1 second group
        '{1'b1, 10'h030, 32'h0000_0500, 4'd3},
        '{1'b0, 10'h040, 32'h0000_0500, 4'd3},   // R3 set pending
        '{1'b1, 10'h040, 32'h0000_0100, 4'd3},
        '{1'b0, 10'h030, 32'h0000_0400, 4'd3},   // R3 clear pending
        '{1'b1, 10'h101, 32'hA1B2_C3D4, 4'd6},
        '{1'b0, 10'h101, 32'hA1B2_C3D4, 4'd6},   // R6 priority word
        '{1'b0, 10'h100, 32'h0000_0000, 4'd6},   // R6 neighbour untouched
        '{1'b1, 10'h200, 32'h0000_0021, 4'd7},
        '{1'b0, 10'h031, 32'h0000_0002, 4'd7},   // R7 trigger line 33
        '{1'b1, 10'h200, 32'h0000_0040, 4'd7},
        '{1'b0, 10'h031, 32'h0000_0002, 4'd7},   // R7 line 64 ignored
        '{1'b0, 10'h030, 32'h0000_0400, 4'd7},   // R7 no wrap to group 0
        '{1'b1, 10'h012, 32'hFFFF_FFFF, 4'd9},
        '{1'b0, 10'h012, 32'h0000_0000, 4'd9},   // R9 group beyond range
        '{1'b0, 10'h3F0, 32'h0000_0000, 4'd9},   // R9 unmapped
        '{1'b0, 10'h200, 32'h0000_0000, 4'd9},   // R9 trigger reads zero
        '{1'b0, 10'h010, 32'h0000_00C3, 4'd9}    // R9 stray write ignored
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [9:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NL-1:0]     hw_req = '0;
    logic [NL-1:0]     hw_active = '0;
    logic [NL-1:0]     irq_enable;
    logic [NL-1:0]     irq_pending;
    logic [8*NL-1:0]   irq_priority;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irqb_bank #(.NUM_GROUPS(NG)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rvalid   (bus_rvalid),
        .hw_req       (hw_req),
        .hw_active    (hw_active),
        .irq_enable   (irq_enable),
        .irq_pending  (irq_pending),
        .irq_priority (irq_priority)
    );

    task automatic check(input bit ok, input string rq, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        check(bus_rvalid == 1'b1, "R9 rvalid", 64'(bus_rvalid), 64'd1);
        d = bus_rdata;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(irq_enable == '0, "R10 enable", 64'(irq_enable), 64'd0);
        check(irq_pending == '0, "R10 pending", 64'(irq_pending), 64'd0);
        check(irq_priority == '0, "R10 priority", 64'(irq_priority[63:0]), 64'd0);
        check(bus_rvalid == 1'b0, "R10 rvalid", 64'(bus_rvalid), 64'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].wr) begin
                bus_write(VECS[k].addr, VECS[k].data);
            end else begin
                bus_read(VECS[k].addr, got);
                check(got == VECS[k].data, $sformatf("R%0d vector %0d", VECS[k].rq, k),
                      64'(got), 64'(VECS[k].data));
            end
        end

        // R9 valid drops after a single read
        @(negedge clk);
        check(bus_rvalid == 1'b0, "R9 rvalid single", 64'(bus_rvalid), 64'd0);

        // R1 enable vector at the port
        check(irq_enable == 64'h8000_0001_0000_00C3, "R1 port", 64'(irq_enable),
              64'h8000_0001_0000_00C3);
        // R6 byte layout at the port: lines 4..7
        check(irq_priority[63:32] == 32'hA1B2_C3D4, "R6 port word",
              64'(irq_priority[63:32]), 64'hA1B2_C3D4);
        check(irq_priority[8*7 +: 8] == 8'hA1, "R6 line7", 64'(irq_priority[8*7 +: 8]),
              64'hA1);

        // R4 hardware request pulse
        @(negedge clk);
        hw_req = '0; hw_req[40] = 1'b1;
        @(negedge clk);
        hw_req = '0;
        check(irq_pending[40] == 1'b1, "R4 hw set", 64'(irq_pending[40]), 64'd1);

        // R4 collision: set wins over clear on line 41
        @(negedge clk);
        hw_req[41] = 1'b1;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'h041; bus_wdata = 32'h0000_0200;
        @(negedge clk);
        hw_req = '0; bus_req = 1'b0; bus_we = 1'b0;
        check(irq_pending[41] == 1'b1, "R4 set wins", 64'(irq_pending[41]), 64'd1);
        bus_write(10'h041, 32'h0000_0200);
        check(irq_pending[41] == 1'b0, "R4 clear after", 64'(irq_pending[41]), 64'd0);
        check(irq_pending[40] == 1'b1, "R4 other bit kept", 64'(irq_pending[40]), 64'd1);

        // R5 active view follows inputs, writes ignored
        hw_active = 64'hDEAD_0000_0000_BEEF;
        bus_read(10'h050, got);
        check(got == 32'h0000_BEEF, "R5 active g0", 64'(got), 64'h0000_BEEF);
        bus_read(10'h051, got);
        check(got == 32'hDEAD_0000, "R5 active g1", 64'(got), 64'hDEAD_0000);
        bus_write(10'h050, 32'h0000_0000);
        bus_read(10'h050, got);
        check(got == 32'h0000_BEEF, "R5 write ignored", 64'(got), 64'h0000_BEEF);
        check(irq_enable == 64'h8000_0001_0000_00C3, "R5 enable untouched",
              64'(irq_enable), 64'h8000_0001_0000_00C3);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule